// File: doc/BRIEF.md
# Wrapping Four-Beat Burst Address Generator

This block produces the word address for a four-beat burst into a synchronous SRAM. A burst begins at a rising clock edge where either of two start strobes is high. One strobe comes from the processor side and the other from the controller side. At that edge the external address is captured and the beat index returns to zero. On each later edge where the advance input is high, the beat index moves forward by one and wraps after four beats. The two low address bits follow that beat through one of two orders, and the bits above them stay at their captured value.

A mode input chooses the order. In interleaved order the low bits are the start bits XOR the beat. In linear order they are the start bits plus the beat, modulo four. Every input, the mode included, is sampled at the rising clock edge. The outputs come straight from registered state, so a new address appears just after the edge that caused it.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and right after it is released, `addr_out` is all zeros and `beat` is 0.
- R2: An edge with `strobe_proc` high loads `addr_in` into `addr_out` and sets `beat` to 0, whatever the mode.
- R3: An edge with `strobe_ctrl` high, or with both strobes high, has the same effect as R2.
- R4: On an edge with no strobe and `advance` high, `beat` becomes the old beat plus one, modulo 4, so four advances return it to its value at the start of the burst. With no strobe and `advance` low, `beat` and `addr_out` hold.
- R5: With `linear_mode` captured as 0 (interleaved), `addr_out[1:0]` equals the captured start bits XOR `beat`. Start 01 gives 01, 00, 11, 10.
- R6: With `linear_mode` captured as 1 (linear), `addr_out[1:0]` equals the captured start bits plus `beat`, modulo 4. Start 01 gives 01, 10, 11, 00.
- R7: A strobe during a burst reloads the address and clears `beat`, even when `advance` is high on the same edge.
- R8: Between strobes, `addr_out[ADDR_W-1:2]` never changes, and changes on `addr_in` have no effect on the outputs.
- R9: `linear_mode` is sampled at the rising edge. Changing it between edges leaves `addr_out` unchanged until the next edge, after which the new order applies to the current beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_proc | input | 1 | Processor-side burst start strobe |
| strobe_ctrl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat |
| linear_mode | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_in | input | ADDR_W | Burst start address |
| addr_out | output | ADDR_W | Current burst word address |
| beat | output | 2 | Beat index within the burst |

## Verification
On every cycle the assertions check the following: a strobe loads the address and clears the beat; advancing increments the beat by one; not advancing holds it; the upper bits stay fixed between strobes; and each step moves the low bits in the way the captured mode requires. Some behaviour only the directed scenarios can show: the complete visiting order for a given start in each mode, the return to the start address after the fourth advance, the priority of a restart over a pending advance, and that a mode change made between edges stays invisible until the next edge.

// File: rtl/burst_pkg.sv
package burst_pkg;
   localparam int BEATS_PER_BURST = 4;
   localparam int BEAT_W = $clog2(BEATS_PER_BURST);

   typedef logic [BEAT_W-1:0] beat_t;

   typedef enum logic {
      ORDER_INTERLEAVED = 1'b0,
      ORDER_LINEAR      = 1'b1
   } order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (load) begin
         base_q <= addr_in;
      end
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  logic  advance,
   output beat_t beat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (load) begin
         beat_q <= '0;
      end else if (advance) begin
         beat_q <= beat_q + beat_t'(1);
      end
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
(
   input  beat_t  start_low,
   input  beat_t  beat,
   input  order_e order,
   output beat_t  low_out
);
   localparam int N_ORDERS = 2;
   beat_t lane [N_ORDERS];

   for (genvar g = 0; g < N_ORDERS; g++) begin : g_order
      if (g == int'(ORDER_INTERLEAVED)) begin : g_xor
         assign lane[g] = start_low ^ beat;
      end else begin : g_add
         assign lane[g] = start_low + beat;
      end
   end

   assign low_out = lane[int'(order)];
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_proc,
   input  logic              strobe_ctrl,
   input  logic              advance,
   input  logic              linear_mode,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic [1:0]        beat
);
   localparam int UPPER_W = ADDR_W - BEAT_W;

   if (ADDR_W <= BEAT_W) begin : g_bad_width
      $error("burst_addr_gen: ADDR_W must exceed the beat width");
   end

   logic              start_burst;
   logic [ADDR_W-1:0] base_q;
   beat_t             beat_q;
   order_e            order_q;
   beat_t             low_w;

   assign start_burst = strobe_proc | strobe_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         order_q <= ORDER_INTERLEAVED;
      end else begin
         order_q <= order_e'(linear_mode);
      end
   end

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_burst),
      .addr_in (addr_in),
      .base_q  (base_q)
   );

   burst_beat_ctr u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_burst),
      .advance (advance),
      .beat_q  (beat_q)
   );

   burst_order_map u_map (
      .start_low (base_q[BEAT_W-1:0]),
      .beat      (beat_q),
      .order     (order_q),
      .low_out   (low_w)
   );

   assign addr_out = {base_q[ADDR_W-1 -: UPPER_W], low_w};
   assign beat     = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strobe_proc,
   input logic              strobe_ctrl,
   input logic              advance,
   input logic              linear_mode,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out,
   input logic [1:0]        beat
);
   logic go;
   assign go = strobe_proc | strobe_ctrl;

   // R2 / R3 / R7
   a_r2_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (beat == 2'd0) && (addr_out == $past(addr_in)));

   // R4
   a_r4_advance_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && advance) |=> beat == $past(beat) + 2'd1);

   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && !advance) |=> $stable(beat));

   // R8
   a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(addr_out[ADDR_W-1:2]));

   // R5: with interleaved order captured on both edges, the low bits change by the XOR of the beat change
   a_r5_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && advance && !linear_mode && !$past(linear_mode)) |=>
         ((addr_out[1:0] ^ $past(addr_out[1:0])) == (beat ^ $past(beat))));

   // R6: with linear order captured on both edges, each advance adds one to the low bits
   a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && advance && linear_mode && $past(linear_mode)) |=>
         (addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .strobe_proc (strobe_proc),
   .strobe_ctrl (strobe_ctrl),
   .advance     (advance),
   .linear_mode (linear_mode),
   .addr_in     (addr_in),
   .addr_out    (addr_out),
   .beat        (beat)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strobe_proc = 1'b0;
   logic          strobe_ctrl = 1'b0;
   logic          advance = 1'b0;
   logic          linear_mode = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic [1:0]    beat;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
      .advance(advance), .linear_mode(linear_mode), .addr_in(addr_in),
      .addr_out(addr_out), .beat(beat)
   );

   function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] start, int b, bit lin);
      logic [1:0] lo;
      if (lin) lo = 2'((int'(start[1:0]) + b) % 4);
      else     lo = start[1:0] ^ 2'(b);
      return {start[AW-1:2], lo};
   endfunction

   task automatic chk(string tag, logic [AW-1:0] got_a, logic [AW-1:0] exp_a,
                      logic [1:0] got_b, logic [1:0] exp_b);
      n_cmp++;
      if (got_a !== exp_a || got_b !== exp_b) begin
         n_bad++;
         $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
                  tag, got_a, got_b, exp_a, exp_b);
      end
   endtask

   // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
   task automatic cyc(bit sp, bit sc, bit adv, logic [AW-1:0] a);
      strobe_proc = sp; strobe_ctrl = sc; advance = adv; addr_in = a;
      @(posedge clk);
      @(negedge clk);
      strobe_proc = 1'b0; strobe_ctrl = 1'b0; advance = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 during reset", addr_out, '0, beat, 2'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", addr_out, '0, beat, 2'd0);
   endtask

   task automatic t_full_burst(string tag, bit lin, bit sp, bit sc, logic [AW-1:0] start);
      linear_mode = lin;
      cyc(sp, sc, 1'b0, start);
      chk({tag, " load"}, addr_out, start, beat, 2'd0);
      for (int k = 1; k <= 4; k++) begin
         cyc(1'b0, 1'b0, 1'b1, ~start);
         chk({tag, " step"}, addr_out, expect_addr(start, k % 4, lin), beat, 2'(k % 4));
      end
   endtask

   task automatic t_hold();
      logic [AW-1:0] s = 17'h0A5F2;
      linear_mode = 1'b1;
      cyc(1'b1, 1'b0, 1'b0, s);
      cyc(1'b0, 1'b0, 1'b1, s);
      for (int k = 0; k < 3; k++) begin
         cyc(1'b0, 1'b0, 1'b0, 17'h1FFFF - AW'(k));
         chk("R4/R8 hold without advance", addr_out, expect_addr(s, 1, 1'b1), beat, 2'd1);
      end
   endtask

   task automatic t_restart();
      logic [AW-1:0] s1 = 17'h12343;
      logic [AW-1:0] s2 = 17'h00401;
      linear_mode = 1'b0;
      cyc(1'b0, 1'b1, 1'b0, s1);
      cyc(1'b0, 1'b0, 1'b1, s1);
      cyc(1'b0, 1'b0, 1'b1, s1);
      chk("R5 mid burst", addr_out, expect_addr(s1, 2, 1'b0), beat, 2'd2);
      cyc(1'b1, 1'b0, 1'b1, s2);
      chk("R7 restart beats advance", addr_out, s2, beat, 2'd0);
      cyc(1'b1, 1'b1, 1'b1, s1);
      chk("R3 both strobes", addr_out, s1, beat, 2'd0);
   endtask

   task automatic t_mode_edge();
      logic [AW-1:0] s = 17'h0F0F1;
      linear_mode = 1'b0;
      cyc(1'b1, 1'b0, 1'b0, s);
      cyc(1'b0, 1'b0, 1'b1, s);
      chk("R5 interleaved beat1", addr_out, expect_addr(s, 1, 1'b0), beat, 2'd1);
      linear_mode = 1'b1;
      #3;
      chk("R9 mode change before edge", addr_out, expect_addr(s, 1, 1'b0), beat, 2'd1);
      cyc(1'b0, 1'b0, 1'b0, s);
      chk("R9 mode change after edge", addr_out, expect_addr(s, 1, 1'b1), beat, 2'd1);
   endtask

   initial begin
      #20_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_full_burst("R2 R5 interleaved proc", 1'b0, 1'b1, 1'b0, 17'h1ABC1);
      t_full_burst("R3 R6 linear ctrl", 1'b1, 1'b0, 1'b1, 17'h1ABC1);
      t_full_burst("R5 interleaved start 10", 1'b0, 1'b0, 1'b1, 17'h00012);
      t_full_burst("R6 linear start 11", 1'b1, 1'b1, 1'b0, 17'h15557);
      t_hold();
      t_restart();
      t_mode_edge();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule